// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block sits between a host bus and a NOR-style flash array. It turns host write cycles into commands. Single-cycle opcodes take effect at once. Two-cycle opcodes wait for a second write that supplies the address, the data or a confirm code. Only the low data byte carries an opcode; the upper byte matters only as program data. The block chooses what a host read returns: the array, the identifier space, the query space or the status register. It drives one-cycle requests to an abstract erase/program engine, which reports back on a single busy line.

The block keeps one lock bit per block; a bit value of 0 means the block is locked. It refuses operations on locked blocks while write protect is low, and it changes lock bits only while write protect is high. It also counts a buffered write of N+1 words, which must be followed by a confirm, and tracks whether the engine's operation is suspended. Sticky error flags record command-sequence errors and refused or aborted operations until a clear-status command.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, rd_mode is 0 (array), status is 8'h80 with an idle engine, every block is unlocked, sts_cfg is 0 and no request, suspend, resume or buffer strobe is active.
- R2: In the idle state, a write whose low data byte is FFh, 90h, 98h or 70h sets rd_mode to 0, 1, 2 or 3 (array, identifier, query, status) on the following cycle, whatever the upper data byte holds.
- R3: A 40h or 10h write followed by any write raises eng_req for one cycle after the second write, with eng_op=0, eng_addr and the full 16-bit eng_data taken from that write; rd_mode becomes 3.
- R4: 20h then D0h raises eng_req with eng_op=1 and the confirm address; 30h then D0h raises eng_req with eng_op=2. Any other second byte issues no request, sets status bit 5 and sets rd_mode to 0.
- R5: E8h, then a count N below BUF_DEPTH, then N+1 data writes each pulse buf_wr with buf_idx 0..N and buf_data; a following D0h raises eng_req with eng_op=3, eng_len=N and eng_addr equal to the first data write's address.
- R6: A non-D0h byte in the buffered-write confirm slot, or a count of BUF_DEPTH or more, sets status bit 4 and issues no request; after a rejected count the next write is decoded as a fresh command.
- R7: 60h then 01h locks the block addressed by the top BLK_BITS address bits; 60h then D0h unlocks all blocks. Either takes effect only while wp_n is 1; with wp_n at 0 the lock bits stay unchanged and status bit 4 is set.
- R8: While wp_n is 0, a program, block erase or buffered write aimed at a locked block issues no request and sets status bit 4; with wp_n at 1 it proceeds.
- R9: B0h while eng_busy is 1 pulses eng_suspend and sets status bit 6, unless the active block is locked and wp_n is 0, in which case status bit 4 is set instead. B0h while eng_busy is 0 has no effect. A lone D0h while suspended pulses eng_resume and clears bit 6.
- R10: status is {~eng_busy, suspended, sequence error, operation error, 4'b0000}; 50h clears bits 5 and 4.
- R11: An unrecognised idle opcode, or a lone D0h with nothing suspended, sets status bit 5 and rd_mode to 0. An operation that would start while eng_busy is 1 is refused with status bit 5 set.
- R12: B8h followed by a write loads its low data byte into sts_cfg.
- R13: A B0h write in the cycle in which eng_busy falls is ignored: no suspend pulse and no suspended flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | AW | Host write address |
| wr_data | input | 16 | Host write data; the low byte carries opcodes |
| wp_n | input | 1 | Write-protect input, 1 allows lock changes and locked-block operations |
| eng_busy | input | 1 | Engine is running an operation |
| eng_req | output | 1 | One-cycle operation request |
| eng_op | output | 2 | 0 program, 1 block erase, 2 chip erase, 3 buffered program |
| eng_addr | output | AW | Target address of the request |
| eng_data | output | 16 | Program data |
| eng_len | output | CW | Buffered word count minus one |
| eng_suspend | output | 1 | One-cycle suspend request |
| eng_resume | output | 1 | One-cycle resume request |
| buf_wr | output | 1 | One-cycle buffer load strobe |
| buf_idx | output | CW | Buffer slot being loaded |
| buf_data | output | 16 | Word loaded into the buffer |
| rd_mode | output | 2 | Read source: 0 array, 1 identifier, 2 query, 3 status |
| status | output | 8 | Status register |
| sts_cfg | output | 8 | Status-pin configuration code |

## Verification
Suspend decoding and engine completion can fall in the same cycle. The suspend opcode can arrive on the very edge at which the engine drops busy. The bench drives the B0h write and the falling eng_busy at the same negedge. It then requires that no suspend pulse appears and that status reads 8'h80 with bit 6 clear, so the decoder acts only on the busy level sampled at that edge.

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int AW = 16,
  parameter int BLK_BITS = 4,
  parameter int BUF_DEPTH = 16,
  localparam int CW = $clog2(BUF_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [15:0]   wr_data,
  input  logic          wp_n,
  input  logic          eng_busy,
  output logic          eng_req,
  output logic [1:0]    eng_op,
  output logic [AW-1:0] eng_addr,
  output logic [15:0]   eng_data,
  output logic [CW-1:0] eng_len,
  output logic          eng_suspend,
  output logic          eng_resume,
  output logic          buf_wr,
  output logic [CW-1:0] buf_idx,
  output logic [15:0]   buf_data,
  output logic [1:0]    rd_mode,
  output logic [7:0]    status,
  output logic [7:0]    sts_cfg
);
  localparam int NBLK = 1 << BLK_BITS;

  typedef enum logic [3:0] {
    S_IDLE, S_PROG, S_ERASE, S_CHIP, S_BCNT, S_BDATA, S_BCONF, S_LOCK, S_CFG
  } st_t;

  st_t                 st;
  logic [NBLK-1:0]     lock_bits;
  logic                susp, seq_err, op_err;
  logic [BLK_BITS-1:0] act_blk;
  logic [CW-1:0]       b_cnt, b_idx;
  logic [AW-1:0]       b_addr;

  wire [7:0]          op   = wr_data[7:0];
  wire [BLK_BITS-1:0] wblk = wr_addr[AW-1 -: BLK_BITS];
  wire                wlocked = !lock_bits[wblk] && !wp_n;

  logic          go, go_locked;
  logic [1:0]    go_op;
  logic [AW-1:0] go_addr;
  logic [CW-1:0] go_len;

  always_comb begin
    go = 1'b0;
    go_locked = wlocked;
    go_op = 2'd0;
    go_addr = wr_addr;
    go_len = '0;
    case (st)
      S_PROG:  go = wr_en;
      S_ERASE: begin go = wr_en && op == 8'hD0; go_op = 2'd1; end
      S_CHIP:  begin go = wr_en && op == 8'hD0; go_op = 2'd2; go_locked = 1'b0; end
      S_BCONF: begin
        go = wr_en && op == 8'hD0;
        go_op = 2'd3;
        go_addr = b_addr;
        go_len = b_cnt;
        go_locked = !lock_bits[b_addr[AW-1 -: BLK_BITS]] && !wp_n;
      end
      default: go = 1'b0;
    endcase
  end

  assign status = {~eng_busy, susp, seq_err, op_err, 4'b0000};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      lock_bits <= '1;
      susp <= 1'b0;
      seq_err <= 1'b0;
      op_err <= 1'b0;
      act_blk <= '0;
      b_cnt <= '0;
      b_idx <= '0;
      b_addr <= '0;
      eng_req <= 1'b0;
      eng_op <= 2'd0;
      eng_addr <= '0;
      eng_data <= '0;
      eng_len <= '0;
      eng_suspend <= 1'b0;
      eng_resume <= 1'b0;
      buf_wr <= 1'b0;
      buf_idx <= '0;
      buf_data <= '0;
      rd_mode <= 2'd0;
      sts_cfg <= 8'd0;
    end else begin
      eng_req <= 1'b0;
      eng_suspend <= 1'b0;
      eng_resume <= 1'b0;
      buf_wr <= 1'b0;
      if (wr_en) begin
        case (st)
          S_IDLE: begin
            case (op)
              8'hFF: rd_mode <= 2'd0;
              8'h90: rd_mode <= 2'd1;
              8'h98: rd_mode <= 2'd2;
              8'h70: rd_mode <= 2'd3;
              8'h50: begin seq_err <= 1'b0; op_err <= 1'b0; end
              8'h40, 8'h10: st <= S_PROG;
              8'h20: st <= S_ERASE;
              8'h30: st <= S_CHIP;
              8'hE8: st <= S_BCNT;
              8'h60: st <= S_LOCK;
              8'hB8: st <= S_CFG;
              8'hB0: if (eng_busy && !susp) begin
                if (!lock_bits[act_blk] && !wp_n) op_err <= 1'b1;
                else begin eng_suspend <= 1'b1; susp <= 1'b1; end
              end
              8'hD0: if (susp) begin
                eng_resume <= 1'b1;
                susp <= 1'b0;
              end else begin
                seq_err <= 1'b1;
                rd_mode <= 2'd0;
              end
              default: begin seq_err <= 1'b1; rd_mode <= 2'd0; end
            endcase
          end
          S_PROG: st <= S_IDLE;
          S_ERASE, S_CHIP: begin
            st <= S_IDLE;
            if (op != 8'hD0) begin seq_err <= 1'b1; rd_mode <= 2'd0; end
          end
          S_BCNT: begin
            if (int'(op) >= BUF_DEPTH) begin
              op_err <= 1'b1;
              st <= S_IDLE;
            end else begin
              b_cnt <= op[CW-1:0];
              b_idx <= '0;
              st <= S_BDATA;
            end
          end
          S_BDATA: begin
            buf_wr <= 1'b1;
            buf_idx <= b_idx;
            buf_data <= wr_data;
            if (b_idx == '0) b_addr <= wr_addr;
            if (b_idx == b_cnt) st <= S_BCONF;
            else b_idx <= b_idx + 1'b1;
          end
          S_BCONF: begin
            st <= S_IDLE;
            if (op != 8'hD0) op_err <= 1'b1;
          end
          S_LOCK: begin
            st <= S_IDLE;
            if (op == 8'h01 || op == 8'hD0) begin
              if (!wp_n) op_err <= 1'b1;
              else if (op == 8'h01) lock_bits[wblk] <= 1'b0;
              else lock_bits <= '1;
            end else begin
              seq_err <= 1'b1;
              rd_mode <= 2'd0;
            end
          end
          S_CFG: begin
            sts_cfg <= op;
            st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
        if (go) begin
          if (eng_busy) seq_err <= 1'b1;
          else if (go_locked) op_err <= 1'b1;
          else begin
            eng_req <= 1'b1;
            eng_op <= go_op;
            eng_addr <= go_addr;
            eng_data <= wr_data;
            eng_len <= go_len;
            act_blk <= go_addr[AW-1 -: BLK_BITS];
            rd_mode <= 2'd3;
          end
        end
      end
    end
  end

  p_excl_pulses_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eng_req, eng_suspend, eng_resume}));

  p_lock_wp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lock_bits) |-> $past(wp_n));

  p_req_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |-> !$past(eng_busy));

  p_susp_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_suspend |-> $past(eng_busy) && susp);

  p_resume_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_resume |-> $past(susp) && !susp);

  p_locked_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && eng_op != 2'd2) |-> (lock_bits[eng_addr[AW-1 -: BLK_BITS]] || $past(wp_n)));
endmodule

// File: tb/sim_flash_cmd_ctrl.sv
module sim_flash_cmd_ctrl;
  localparam int AW = 16;
  localparam int CW = 4;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, wp_n = 1'b1, eng_busy = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic eng_req, eng_suspend, eng_resume, buf_wr;
  logic [1:0] eng_op, rd_mode;
  logic [AW-1:0] eng_addr;
  logic [15:0] eng_data, buf_data;
  logic [CW-1:0] eng_len, buf_idx;
  logic [7:0] status, sts_cfg;
  int errs = 0, checks = 0;

  always #2.5 clk = ~clk;

  flash_cmd_ctrl #(.AW(AW), .BLK_BITS(4), .BUF_DEPTH(16)) u0 (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .wp_n, .eng_busy,
    .eng_req, .eng_op, .eng_addr, .eng_data, .eng_len, .eng_suspend, .eng_resume,
    .buf_wr, .buf_idx, .buf_data, .rd_mode, .status, .sts_cfg);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [15:0] d);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clr();
    wr(16'h0, 16'h0050);
  endtask

  task automatic t_reset();
    chk("R1 rd_mode", rd_mode, 0);
    chk("R1 status", status, 32'h80);
    chk("R1 pulses", {eng_req, eng_suspend, eng_resume, buf_wr}, 0);
    chk("R1 sts_cfg", sts_cfg, 0);
    wp_n = 1'b0;
    wr(16'hF000, 16'h0040); wr(16'hF004, 16'h1111);
    chk("R1 unlocked at reset", eng_req, 1);
    wp_n = 1'b1;
  endtask

  task automatic t_read_modes();
    wr(0, 16'h1290); chk("R2 identifier", rd_mode, 1);
    wr(0, 16'hAB98); chk("R2 query", rd_mode, 2);
    wr(0, 16'hFF70); chk("R2 status", rd_mode, 3);
    wr(0, 16'h00FF); chk("R2 array", rd_mode, 0);
  endtask

  task automatic t_program();
    wr(0, 16'hEE40); wr(16'h1234, 16'hBEEF);
    chk("R3 req", {eng_req, eng_op}, {1'b1, 2'd0});
    chk("R3 addr", eng_addr, 16'h1234);
    chk("R3 data", eng_data, 16'hBEEF);
    chk("R3 rd_mode", rd_mode, 3);
    wr(0, 16'h0010); wr(16'h2222, 16'h0A0B);
    chk("R3 alt setup", {eng_req, eng_data}, {1'b1, 16'h0A0B});
  endtask

  task automatic t_erase();
    wr(0, 16'h0020); chk("R4 wait confirm", eng_req, 0);
    wr(16'h5000, 16'h00D0);
    chk("R4 block erase", {eng_req, eng_op, eng_addr}, {1'b1, 2'd1, 16'h5000});
    wr(0, 16'h0030); wr(0, 16'h00D0);
    chk("R4 chip erase", {eng_req, eng_op}, {1'b1, 2'd2});
    wr(0, 16'h0020); wr(16'h5000, 16'h00FF);
    chk("R4 bad confirm", {eng_req, rd_mode, status}, {1'b0, 2'd0, 8'hA0});
    clr(); chk("R10 clear", status, 32'h80);
  endtask

  task automatic t_buffer();
    wr(0, 16'h00E8); wr(0, 16'h0002);
    for (int i = 0; i < 3; i++) begin
      wr(16'h6000 + 16'(i), 16'h100 + 16'(i));
      chk("R5 buf strobe", {buf_wr, buf_idx, buf_data}, {1'b1, 4'(i), 16'h100 + 16'(i)});
    end
    chk("R5 no early req", eng_req, 0);
    wr(0, 16'h00D0);
    chk("R5 req", {eng_req, eng_op, eng_len, eng_addr}, {1'b1, 2'd3, 4'd2, 16'h6000});
  endtask

  task automatic t_buf_abort();
    wr(0, 16'h00E8); wr(0, 16'h0001); wr(16'h6000, 1); wr(16'h6001, 2);
    wr(0, 16'h0070);
    chk("R6 abort", {eng_req, status}, {1'b0, 8'h90});
    clr();
    wr(0, 16'h00E8); wr(0, 16'h0010);
    chk("R6 count too big", {buf_wr, status}, {1'b0, 8'h90});
    wr(0, 16'h0090);
    chk("R6 next is command", {buf_wr, rd_mode}, {1'b0, 2'd1});
    clr();
  endtask

  task automatic t_lock();
    wp_n = 1'b0;
    wr(16'h3000, 16'h0060); wr(16'h3000, 16'h0001);
    chk("R7 lock refused", status, 32'h90);
    clr();
    wr(0, 16'h0040); wr(16'h3000, 16'h0001);
    chk("R7 still unlocked", eng_req, 1);
    wp_n = 1'b1;
    wr(16'h3000, 16'h0060); wr(16'h3000, 16'h0001);
    chk("R7 lock ok", status, 32'h80);
    wp_n = 1'b0;
    wr(0, 16'h0040); wr(16'h3010, 16'h0001);
    chk("R8 program refused", {eng_req, status}, {1'b0, 8'h90});
    clr();
    wr(0, 16'h0020); wr(16'h3000, 16'h00D0);
    chk("R8 erase refused", {eng_req, status}, {1'b0, 8'h90});
    clr();
    wr(0, 16'h00E8); wr(0, 0); wr(16'h3004, 16'h5555); wr(0, 16'h00D0);
    chk("R8 buffer refused", {eng_req, status}, {1'b0, 8'h90});
    clr();
    wr(0, 16'h0040); wr(16'h4000, 16'h0001);
    chk("R8 other block ok", eng_req, 1);
    wp_n = 1'b1;
    wr(0, 16'h0040); wr(16'h3000, 16'h0001);
    chk("R8 wp high ok", eng_req, 1);
    wp_n = 1'b0;
    wr(0, 16'h0060); wr(0, 16'h00D0);
    chk("R7 unlock refused", status, 32'h90);
    clr();
    wr(0, 16'h0040); wr(16'h3000, 16'h0001);
    chk("R7 still locked", eng_req, 0);
    clr();
    wp_n = 1'b1;
    wr(0, 16'h0060); wr(0, 16'h00D0);
    wp_n = 1'b0;
    wr(0, 16'h0040); wr(16'h3000, 16'h0001);
    chk("R7 unlock all", eng_req, 1);
    wp_n = 1'b1;
  endtask

  task automatic t_suspend();
    wr(0, 16'h0040); wr(16'h5000, 16'h0001);
    eng_busy = 1'b1;
    wr(0, 16'h00B0);
    chk("R9 suspend", {eng_suspend, status}, {1'b1, 8'h40});
    eng_busy = 1'b0;
    wr(0, 16'h00D0);
    chk("R9 resume", {eng_resume, status}, {1'b1, 8'h80});
    wr(0, 16'h00B0);
    chk("R9 idle suspend ignored", {eng_suspend, status}, {1'b0, 8'h80});
    wr(16'h3000, 16'h0060); wr(16'h3000, 16'h0001);
    wr(0, 16'h0040); wr(16'h3000, 16'h0001);
    eng_busy = 1'b1; wp_n = 1'b0;
    wr(0, 16'h00B0);
    chk("R9 locked suspend", {eng_suspend, status}, {1'b0, 8'h10});
    wr(0, 16'h0040); wr(16'h4000, 16'h0001);
    chk("R11 busy refuse", {eng_req, status}, {1'b0, 8'h30});
    eng_busy = 1'b0; wp_n = 1'b1;
    clr();
    wr(0, 16'h0060); wr(0, 16'h00D0);
  endtask

  task automatic t_errors();
    wr(0, 16'h0090); wr(0, 16'h0077);
    chk("R11 unknown", {rd_mode, status}, {2'd0, 8'hA0});
    clr();
    wr(0, 16'h00D0);
    chk("R11 lone confirm", {eng_resume, status}, {1'b0, 8'hA0});
    clr();
    wr(0, 16'h0060); wr(0, 16'h0002);
    chk("R11 bad lock code", status, 32'hA0);
    clr();
  endtask

  task automatic t_cfg();
    wr(0, 16'h00B8); wr(0, 16'hFF03);
    chk("R12 cfg", sts_cfg, 3);
  endtask

  task automatic t_race();
    wr(0, 16'h0040); wr(16'h1000, 16'h0001);
    eng_busy = 1'b1;
    @(negedge clk);
    wr_addr = 0; wr_data = 16'h00B0; wr_en = 1'b1; eng_busy = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R13 race suspend", {eng_suspend, status}, {1'b0, 8'h80});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_modes();
    t_program();
    t_erase();
    t_buffer();
    t_buf_abort();
    t_lock();
    t_suspend();
    t_errors();
    t_cfg();
    t_race();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule